// File: doc/BRIEF.md
# Parallel Camera Pixel Timing Generator

This block produces the parallel video output of a VGA-class image sensor from a single master clock. It drives a 10-bit pixel bus, a pixel clock, a line strobe and a frame strobe. Every output register is clocked on the falling edge of the master clock. The forwarded pixel clock therefore rises half a cycle after each update, while the data is stable.

One pixel leaves per master clock cycle. A frame starts with a stretch of vertical blanking in which the frame strobe is low. Next comes a fixed lead-in guard in which the frame strobe is high and no line is active. Then the rows follow, each a run of active pixels with horizontal blanking between rows. The frame ends with a fixed trail-out guard. Active width, active height, horizontal blanking, vertical blanking and the guard length are static parameters. The vertical blanking count is the total number of line-idle cycles between two frames and includes both guards. The payload is a test pattern: column index plus row index, truncated to the bus width.

Top module: `cam_timing_gen`

## Requirements
- R1: The frame strobe, line strobe and pixel bus change only on falling master-clock edges and hold their values across the rising edge that follows.
- R2: The pixel clock output equals the master clock once reset has been released, so it rises half a cycle after each output update. While reset is sampled high on a falling edge, the pixel clock is held low from that edge on.
- R3: Each frame has exactly ACT_H rows, and in each row the line strobe stays high for exactly ACT_W consecutive cycles.
- R4: Between two rows of a frame, the line strobe is low for exactly H_BLANK cycles while the frame strobe stays high.
- R5: The frame strobe rises exactly GUARD (default 6) cycles before the first line strobe of the frame rises.
- R6: The frame strobe falls exactly GUARD cycles after the last line strobe of the frame falls.
- R7: The frame strobe is low for exactly V_BLANK - 2*GUARD cycles between frames.
- R8: While the line strobe is high, the pixel bus carries (column + row) mod 2^10. The column counts from 0 at the first pixel of a row, and the row counts from 0 at the first row of a frame.
- R9: While the line strobe is low, the pixel bus is zero.
- R10: The line strobe is never high while the frame strobe is low.
- R11: A falling edge that samples the synchronous reset high drives both strobes and the bus low. Count that edge as cycle 0. After release, the frame strobe rises at cycle V_BLANK - 2*GUARD and the first line strobe rises at cycle V_BLANK - GUARD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all state updates on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| pix_clk_o | output | 1 | Forwarded pixel clock, a gated copy of the master clock |
| frame_valid_o | output | 1 | Frame strobe |
| line_valid_o | output | 1 | Line strobe |
| pix_data_o | output | PIX_W | Pixel bus (test pattern) |

## Verification
Every strobe and data value is due at the falling edge that follows the cycle's decision. The bench numbers those edges from the last reset edge and, for each edge, computes the expected strobe and pattern values from the frame arithmetic alone. It reads the outputs 2 ns after each falling edge and again 2 ns after the next rising edge. The two reads must agree, and the pixel clock must read low at the first and high at the second. The frame boundaries, the row turnarounds and the bus wrap past 1023 are fixed at hand-computed cycle numbers. A reset applied in the middle of a line must clear all outputs at the very next falling edge.

// File: rtl/cam_tg_pkg.sv
package cam_tg_pkg;

  typedef enum logic [2:0] {
    PH_VBLANK = 3'd0,
    PH_LEAD   = 3'd1,
    PH_LINE   = 3'd2,
    PH_HBLANK = 3'd3,
    PH_TRAIL  = 3'd4
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cam_tg_count.sv
// Falling-edge counter with synchronous clear and increment; exposes next value.
module cam_tg_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wrap_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  always_comb begin
    if (wrap_i)     cnt_nxt_o = '0;
    else if (inc_i) cnt_nxt_o = cnt_o + 1'b1;
    else            cnt_nxt_o = cnt_o;
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) cnt_o <= '0;
    else       cnt_o <= cnt_nxt_o;
  end

endmodule

// File: rtl/cam_tg_seq.sv
// Frame sequencer: phase state, span counter (doubles as column) and row counter.
module cam_tg_seq
  import cam_tg_pkg::*;
#(
  parameter int unsigned ACT_W   = 640,
  parameter int unsigned ACT_H   = 480,
  parameter int unsigned H_BLANK = 160,
  parameter int unsigned V_BLANK = 45,
  parameter int unsigned GUARD   = 6,
  parameter int unsigned COL_W   = 10,
  parameter int unsigned ROW_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output phase_e           phase_nxt_o,
  output logic [COL_W-1:0] col_nxt_o,
  output logic [ROW_W-1:0] row_nxt_o
);

  localparam int unsigned VB_LOW = V_BLANK - 2 * GUARD;

  phase_e           phase_q;
  phase_e           phase_d;
  logic [COL_W-1:0] span_q;
  logic [ROW_W-1:0] row_q;
  logic             span_last;
  logic             row_last;
  logic             row_clr;
  logic             row_inc;

  always_comb begin
    unique case (phase_q)
      PH_VBLANK: span_last = (span_q == COL_W'(VB_LOW - 1));
      PH_LEAD:   span_last = (span_q == COL_W'(GUARD - 1));
      PH_LINE:   span_last = (span_q == COL_W'(ACT_W - 1));
      PH_HBLANK: span_last = (span_q == COL_W'(H_BLANK - 1));
      PH_TRAIL:  span_last = (span_q == COL_W'(GUARD - 1));
      default:   span_last = 1'b1;
    endcase
  end

  assign row_last = (row_q == ROW_W'(ACT_H - 1));

  always_comb begin
    phase_d = phase_q;
    if (span_last) begin
      unique case (phase_q)
        PH_VBLANK: phase_d = PH_LEAD;
        PH_LEAD:   phase_d = PH_LINE;
        PH_LINE:   phase_d = row_last ? PH_TRAIL : PH_HBLANK;
        PH_HBLANK: phase_d = PH_LINE;
        PH_TRAIL:  phase_d = PH_VBLANK;
        default:   phase_d = PH_VBLANK;
      endcase
    end
  end

  assign row_clr = span_last && (phase_q == PH_LEAD);
  assign row_inc = span_last && (phase_q == PH_HBLANK);

  always_ff @(negedge clk_i) begin
    if (rst_i) phase_q <= PH_VBLANK;
    else       phase_q <= phase_d;
  end

  cam_tg_count #(.CNT_W(COL_W)) span_ctr_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wrap_i    (span_last),
    .inc_i     (1'b1),
    .cnt_o     (span_q),
    .cnt_nxt_o (col_nxt_o)
  );

  cam_tg_count #(.CNT_W(ROW_W)) row_ctr_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wrap_i    (row_clr),
    .inc_i     (row_inc),
    .cnt_o     (row_q),
    .cnt_nxt_o (row_nxt_o)
  );

  assign phase_nxt_o = phase_d;

endmodule

// File: rtl/cam_tg_out.sv
// Falling-edge output registers, test pattern and pixel clock gate.
module cam_tg_out
  import cam_tg_pkg::*;
#(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned COL_W = 10,
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  phase_e           phase_nxt_i,
  input  logic [COL_W-1:0] col_nxt_i,
  input  logic [ROW_W-1:0] row_nxt_i,
  output logic             pix_clk_o,
  output logic             fv_o,
  output logic             lv_o,
  output logic [PIX_W-1:0] data_o
);

  localparam int unsigned SUM_W = max2(COL_W, ROW_W) + PIX_W;

  logic [SUM_W-1:0] pat_sum;
  logic             run_q;
  logic             line_nxt;

  assign pat_sum  = SUM_W'(col_nxt_i) + SUM_W'(row_nxt_i);
  assign line_nxt = (phase_nxt_i == PH_LINE);

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      fv_o   <= 1'b0;
      lv_o   <= 1'b0;
      data_o <= '0;
      run_q  <= 1'b0;
    end else begin
      fv_o   <= (phase_nxt_i != PH_VBLANK);
      lv_o   <= line_nxt;
      data_o <= line_nxt ? pat_sum[PIX_W-1:0] : '0;
      run_q  <= 1'b1;
    end
  end

  // run_q only changes while the clock is low, so the gate cannot glitch.
  assign pix_clk_o = clk_i & run_q;

endmodule

// File: rtl/cam_timing_gen.sv
module cam_timing_gen
  import cam_tg_pkg::*;
#(
  parameter int unsigned ACT_W   = 640,
  parameter int unsigned ACT_H   = 480,
  parameter int unsigned H_BLANK = 160,
  parameter int unsigned V_BLANK = 45,
  parameter int unsigned GUARD   = 6,
  parameter int unsigned PIX_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic             pix_clk_o,
  output logic             frame_valid_o,
  output logic             line_valid_o,
  output logic [PIX_W-1:0] pix_data_o
);

  localparam int unsigned VB_LOW   = V_BLANK - 2 * GUARD;
  localparam int unsigned MAX_SPAN = max2(max2(ACT_W, H_BLANK), max2(VB_LOW, GUARD));
  localparam int unsigned COL_W    = $clog2(MAX_SPAN + 1);
  localparam int unsigned ROW_W    = $clog2(ACT_H + 1);

  phase_e           phase_nxt;
  logic [COL_W-1:0] col_nxt;
  logic [ROW_W-1:0] row_nxt;

  cam_tg_seq #(
    .ACT_W   (ACT_W),
    .ACT_H   (ACT_H),
    .H_BLANK (H_BLANK),
    .V_BLANK (V_BLANK),
    .GUARD   (GUARD),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_nxt_o (phase_nxt),
    .col_nxt_o   (col_nxt),
    .row_nxt_o   (row_nxt)
  );

  cam_tg_out #(
    .PIX_W (PIX_W),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) out_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_nxt_i (phase_nxt),
    .col_nxt_i   (col_nxt),
    .row_nxt_i   (row_nxt),
    .pix_clk_o   (pix_clk_o),
    .fv_o        (frame_valid_o),
    .lv_o        (line_valid_o),
    .data_o      (pix_data_o)
  );

endmodule

// File: rtl/cam_timing_gen_chk.sv
module cam_timing_gen_chk #(
  parameter int unsigned ACT_W   = 640,
  parameter int unsigned ACT_H   = 480,
  parameter int unsigned H_BLANK = 160,
  parameter int unsigned V_BLANK = 45,
  parameter int unsigned GUARD   = 6,
  parameter int unsigned PIX_W   = 10
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             fv_i,
  input logic             lv_i,
  input logic [PIX_W-1:0] data_i
);

  logic        lv_q;
  int unsigned hi_run;
  int unsigned lo_run;
  int unsigned vb_run;
  int unsigned lines;

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      lv_q   <= 1'b0;
      hi_run <= 0;
      lo_run <= 0;
      vb_run <= 0;
      lines  <= 0;
    end else begin
      lv_q   <= lv_i;
      hi_run <= lv_i ? hi_run + 1 : 0;
      lo_run <= (fv_i && !lv_i) ? lo_run + 1 : 0;
      vb_run <= fv_i ? 0 : vb_run + 1;
      if (!fv_i)             lines <= 0;
      else if (lv_q && !lv_i) lines <= lines + 1;
    end
  end

  // R3
  lv_len_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    $fell(lv_i) |-> (hi_run == ACT_W));

  // R3
  row_count_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    $fell(fv_i) |-> (lines == ACT_H));

  // R4
  hblank_len_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    ($rose(lv_i) && lines != 0) |-> (lo_run == H_BLANK));

  // R5
  lead_guard_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    ($rose(lv_i) && lines == 0) |-> (lo_run == GUARD));

  // R6
  trail_guard_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    $fell(fv_i) |-> (lo_run == GUARD));

  // R7
  vblank_len_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    $rose(fv_i) |-> (vb_run == V_BLANK - 2 * GUARD));

  // R9
  idle_data_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    !lv_i |-> (data_i == '0));

  // R10
  lv_in_fv_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    lv_i |-> fv_i);

endmodule

bind cam_timing_gen cam_timing_gen_chk #(
  .ACT_W   (ACT_W),
  .ACT_H   (ACT_H),
  .H_BLANK (H_BLANK),
  .V_BLANK (V_BLANK),
  .GUARD   (GUARD),
  .PIX_W   (PIX_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .fv_i   (frame_valid_o),
  .lv_i   (line_valid_o),
  .data_i (pix_data_o)
);

// File: tb/cam_timing_gen_tb.sv
module cam_timing_gen_tb_top;

  localparam int W      = 1020;
  localparam int H      = 8;
  localparam int HB     = 6;
  localparam int VB     = 16;
  localparam int G      = 6;
  localparam int VB_LOW = VB - 2 * G;
  localparam int SPAN   = H * W + (H - 1) * HB;
  localparam int PERIOD = VB + SPAN;
  localparam int NVEC   = 16;

  // {cycle, frame strobe, line strobe, data}; boundaries of R5 R6 R7 R4 R8
  localparam int VEC [NVEC][4] = '{
    '{3,    0, 0, 0},     // R7 last blank cycle
    '{4,    1, 0, 0},     // R5 frame strobe rises
    '{9,    1, 0, 0},     // R5 end of lead guard
    '{10,   1, 1, 0},     // R5 first pixel
    '{1029, 1, 1, 1019},  // R3 last pixel of row 0
    '{1030, 1, 0, 0},     // R4 row gap starts
    '{1035, 1, 0, 0},     // R4 row gap ends
    '{1036, 1, 1, 1},     // R8 row 1 column 0
    '{8208, 1, 1, 1023},  // R8 pattern at top value
    '{8211, 1, 1, 2},     // R8 wrap past 1023
    '{8212, 1, 0, 0},     // R6 last line falls
    '{8217, 1, 0, 0},     // R6 end of trail guard
    '{8218, 0, 0, 0},     // R6 frame strobe falls
    '{8221, 0, 0, 0},     // R7 blank
    '{8222, 1, 0, 0},     // R7 next frame strobe
    '{8228, 1, 1, 0}      // R5 next frame first pixel
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pclk;
  logic       fv;
  logic       lv;
  logic [9:0] data;

  int  checks = 0;
  int  errors = 0;
  int  ti     = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  cam_timing_gen #(
    .ACT_W   (W),
    .ACT_H   (H),
    .H_BLANK (HB),
    .V_BLANK (VB),
    .GUARD   (G),
    .PIX_W   (10)
  ) dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .pix_clk_o     (pclk),
    .frame_valid_o (fv),
    .line_valid_o  (lv),
    .pix_data_o    (data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input int c, output logic efv, output logic elv, output logic [9:0] ed);
    int t;
    int r;
    int k;
    t = c % PERIOD;
    efv = 1'b0; elv = 1'b0; ed = '0;
    if (t >= VB_LOW) begin
      efv = 1'b1;
      t = t - VB_LOW;
      if (t >= G) begin
        t = t - G;
        if (t < SPAN) begin
          r = t / (W + HB);
          k = t % (W + HB);
          if (k < W) begin
            elv = 1'b1;
            ed  = 10'((r + k) % 1024);
          end
        end
      end
    end
  endtask

  task automatic run_span(input int last_c, input bit use_tbl);
    logic       sfv;
    logic       slv;
    logic [9:0] sd;
    logic       efv;
    logic       elv;
    logic [9:0] ed;
    for (int c = 1; c <= last_c; c++) begin
      @(negedge clk); #2;
      sfv = fv; slv = lv; sd = data;
      chk("R2 pixel clock low after falling edge", 32'(pclk), 32'd0);
      @(posedge clk); #2;
      chk("R2 pixel clock high after rising edge", 32'(pclk), 32'd1);
      chk("R1 outputs held across rising edge", {20'd0, fv, lv, data}, {20'd0, sfv, slv, sd});
      model(c, efv, elv, ed);
      chk("R5 R6 R7 R10 R11 frame strobe", 32'(fv), 32'(efv));
      chk("R3 R4 R10 line strobe", 32'(lv), 32'(elv));
      chk("R8 R9 pixel bus", 32'(data), 32'(ed));
      if (use_tbl && ti < NVEC && c == VEC[ti][0]) begin
        chk("R5 R6 R7 table frame strobe", 32'(fv), 32'(VEC[ti][1]));
        chk("R3 R4 table line strobe", 32'(lv), 32'(VEC[ti][2]));
        chk("R8 table pixel bus", 32'(data), 32'(VEC[ti][3]));
        ti++;
      end
    end
  endtask

  task automatic reset_checks(input string tag);
    chk({tag, " R11 frame strobe in reset"}, 32'(fv), 32'd0);
    chk({tag, " R11 line strobe in reset"}, 32'(lv), 32'd0);
    chk({tag, " R11 bus in reset"}, 32'(data), 32'd0);
    chk({tag, " R2 pixel clock gated in reset"}, 32'(pclk), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    reset_checks("power-up");
    rst = 1'b0;
    run_span(8230, 1'b1);
    chk("R5 R6 table fully walked", 32'(ti), 32'(NVEC));

    // Reset in the middle of an active line of the second frame.
    chk("R11 line active before mid-frame reset", 32'(lv), 32'd1);
    rst = 1'b1;
    @(posedge clk); #2;
    reset_checks("mid-line");
    @(posedge clk); #2;
    rst = 1'b0;
    run_span(1100, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule